// File: doc/BRIEF.md
# Flow Control Packet Checker

This block sits on the receive side of a link and validates link-level packets, of which only one kind exists: the flow control packet. Bytes arrive one per beat on a valid-qualified stream with start-of-packet and end-of-packet markers. The block counts the bytes, captures the header fields, and runs a 16-bit CRC over the header while the packet streams in. Every check finishes on the end-of-packet beat.

One cycle after the end-of-packet beat the block gives one of two results. For a clean packet it presents the lane number, an initialisation flag, the 12-bit transmitted-blocks count and the 12-bit credit limit for a single cycle, to be picked up by the per-lane credit logic. For a faulty packet it discards the contents and raises a single error code chosen by a fixed precedence.

Packet layout, first byte first: byte 0 carries the opcode in bits 7:4 and blocks[11:8] in bits 3:0. Byte 1 is blocks[7:0]. Byte 2 carries the lane in bits 7:4 and limit[11:8] in bits 3:0. Byte 3 is limit[7:0]. Bytes 4 and 5 are the received CRC, high byte first.

Top module: `fc_pkt_checker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fc_valid and err_valid are low.
- R2: A packet whose end marker arrives on a byte count other than 6 produces err_valid with err_code 0 (length), whatever its contents.
- R3: The CRC uses polynomial 0x100B and seed 0xFFFF. It is processed MSB first over bytes 0 to 3, with no final inversion, and is compared with byte 4 (high) and byte 5 (low). On a 6-byte packet a mismatch produces err_code 1 (CRC).
- R4: The opcode is byte 0 bits 7:4. Value 0 means normal and value 1 means initialisation. On a 6-byte packet with a good CRC, any other value produces err_code 2 (opcode).
- R5: The lane is byte 2 bits 7:4. A lane is supported if it is below DATA_LANES (default 1) or equals 15. On an otherwise clean packet, an unsupported lane produces err_code 3 (lane).
- R6: When several faults are present, the reported code is that of the highest-precedence fault: length, then CRC, then opcode, then lane.
- R7: A clean packet raises fc_valid for exactly one cycle. In that cycle fc_lane = byte2[7:4], fc_blocks = {byte0[3:0], byte1}, fc_limit = {byte2[3:0], byte3}, and fc_init = 1 exactly when the opcode is 1.
- R8: A result (fc_valid or err_valid, never both) appears in the cycle after an end-of-packet beat and in no other cycle. Beats with in_valid low are skipped without ending or altering the packet.
- R9: Bytes with in_valid high that arrive while no packet is open and in_sop is low are ignored.
- R10: A start marker that arrives while a packet is open drops that packet without a report, and counting starts afresh from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on in_data is valid this cycle |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_data | input | 8 | Received byte |
| fc_valid | output | 1 | One-cycle strobe for a clean packet |
| fc_lane | output | 4 | Lane named by the packet |
| fc_init | output | 1 | Packet carries the initialisation opcode |
| fc_blocks | output | 12 | Transmitted-blocks count |
| fc_limit | output | 12 | Credit limit |
| err_valid | output | 1 | One-cycle strobe for a discarded packet |
| err_code | output | 2 | 0 length, 1 CRC, 2 opcode, 3 lane |

## Verification
The assertions assume that in_sop, in_eop and in_data have meaning only when in_valid is high. They also assume that a packet ends only through an end marker, so every result they expect can be traced to one qualified end-of-packet beat. The stimulus drives the markers only together with in_valid and inserts idle beats between and inside packets. It also sends stray bytes outside packets and restarts packets with an early start marker, which tests the block's handling of framing faults while keeping within those assumptions.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int HDR_BYTES = 4;
    localparam int PKT_BYTES = 6;
    localparam int HDR_W     = 8 * HDR_BYTES;
    localparam int CRC_W     = 16;
    localparam logic [3:0] MGMT_LANE = 4'hF;

    typedef enum logic [1:0] {
        ERR_LENGTH = 2'd0,
        ERR_CRC    = 2'd1,
        ERR_OPCODE = 2'd2,
        ERR_LANE   = 2'd3
    } err_code_e;

    typedef enum logic [3:0] {
        OP_NORMAL = 4'd0,
        OP_INIT   = 4'd1
    } fc_op_e;

    typedef struct packed {
        logic              open;
        logic [2:0]        cnt;
        logic [CRC_W-1:0]  crc;
        logic [HDR_W-1:0]  hdr;
        logic [CRC_W-1:0]  rx_crc;
        logic              fc_valid;
        logic [3:0]        lane;
        logic              init;
        logic [11:0]       blocks;
        logic [11:0]       limit;
        logic              err_valid;
        err_code_e         err_code;
    } chk_state_t;

endpackage

// File: rtl/fcc_crc_step.sv
module fcc_crc_step #(
    parameter int            W    = 16,
    parameter int            DW   = 8,
    parameter logic [W-1:0]  POLY = 16'h100B
) (
    input  logic [W-1:0]  crc_i,
    input  logic [DW-1:0] data_i,
    output logic [W-1:0]  crc_o
);

    always_comb begin
        logic [W-1:0] acc;
        logic         fb;
        acc = crc_i;
        for (int i = DW - 1; i >= 0; i--) begin
            fb  = acc[W-1] ^ data_i[i];
            acc = {acc[W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_o = acc;
    end

endmodule

// File: rtl/fcc_lane_support.sv
module fcc_lane_support #(
    parameter int DATA_LANES = 1
) (
    input  logic [3:0] lane_i,
    output logic       supported_o
);

    logic [15:0] lane_mask;

    for (genvar g = 0; g < 16; g++) begin : g_mask
        assign lane_mask[g] = (g < DATA_LANES) || (g == 15);
    end

    assign supported_o = lane_mask[lane_i];

endmodule

// File: rtl/fcc_classify.sv
module fcc_classify
    import fcc_pkg::*;
(
    input  logic      len_ok_i,
    input  logic      crc_ok_i,
    input  logic [3:0] opcode_i,
    input  logic      lane_ok_i,
    output logic      pass_o,
    output logic      init_o,
    output err_code_e code_o
);

    logic op_ok;

    always_comb begin
        op_ok  = (opcode_i == OP_NORMAL) || (opcode_i == OP_INIT);
        init_o = (opcode_i == OP_INIT);
        pass_o = 1'b0;
        code_o = ERR_LENGTH;
        if (!len_ok_i) begin
            code_o = ERR_LENGTH;
        end else if (!crc_ok_i) begin
            code_o = ERR_CRC;
        end else if (!op_ok) begin
            code_o = ERR_OPCODE;
        end else if (!lane_ok_i) begin
            code_o = ERR_LANE;
        end else begin
            pass_o = 1'b1;
        end
    end

endmodule

// File: rtl/fc_pkt_checker.sv
module fc_pkt_checker
    import fcc_pkg::*;
#(
    parameter int              DATA_LANES = 1,
    parameter logic [15:0]     CRC_POLY   = 16'h100B,
    parameter logic [15:0]     CRC_SEED   = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [7:0]  in_data,
    output logic        fc_valid,
    output logic [3:0]  fc_lane,
    output logic        fc_init,
    output logic [11:0] fc_blocks,
    output logic [11:0] fc_limit,
    output logic        err_valid,
    output logic [1:0]  err_code
);

    localparam logic [2:0] CNT_MAX  = 3'd7;
    localparam logic [2:0] CNT_HDR  = 3'(HDR_BYTES);
    localparam logic [2:0] CNT_PKT  = 3'(PKT_BYTES);
    localparam logic [2:0] IDX_CRCH = 3'(HDR_BYTES);
    localparam logic [2:0] IDX_CRCL = 3'(HDR_BYTES + 1);

    chk_state_t q, d;

    logic              beat_acc;
    logic [2:0]        idx;
    logic [CRC_W-1:0]  crc_base, crc_stepped, crc_n;
    logic [HDR_W-1:0]  hdr_base, hdr_n;
    logic [CRC_W-1:0]  rx_base, rx_n;
    logic [2:0]        cnt_n;
    logic              lane_ok, pass, is_init;
    err_code_e         code;

    // byte path: where the current byte lands
    always_comb begin
        beat_acc = in_valid && (in_sop || q.open);
        idx      = in_sop ? 3'd0 : q.cnt;
        crc_base = in_sop ? CRC_SEED : q.crc;
        hdr_base = in_sop ? '0 : q.hdr;
        rx_base  = in_sop ? '0 : q.rx_crc;
        cnt_n    = (idx == CNT_MAX) ? CNT_MAX : idx + 3'd1;
        if (idx < CNT_HDR) begin
            crc_n = crc_stepped;
            hdr_n = {hdr_base[HDR_W-9:0], in_data};
        end else begin
            crc_n = crc_base;
            hdr_n = hdr_base;
        end
        if (idx == IDX_CRCH) begin
            rx_n = {in_data, rx_base[7:0]};
        end else if (idx == IDX_CRCL) begin
            rx_n = {rx_base[15:8], in_data};
        end else begin
            rx_n = rx_base;
        end
    end

    fcc_crc_step #(
        .W    (CRC_W),
        .DW   (8),
        .POLY (CRC_POLY)
    ) u_crc (
        .crc_i  (crc_base),
        .data_i (in_data),
        .crc_o  (crc_stepped)
    );

    fcc_lane_support #(
        .DATA_LANES (DATA_LANES)
    ) u_lane (
        .lane_i      (hdr_n[15:12]),
        .supported_o (lane_ok)
    );

    fcc_classify u_cls (
        .len_ok_i  (cnt_n == CNT_PKT),
        .crc_ok_i  (crc_n == rx_n),
        .opcode_i  (hdr_n[31:28]),
        .lane_ok_i (lane_ok),
        .pass_o    (pass),
        .init_o    (is_init),
        .code_o    (code)
    );

    always_comb begin
        d           = q;
        d.fc_valid  = 1'b0;
        d.err_valid = 1'b0;
        if (beat_acc) begin
            d.cnt    = cnt_n;
            d.crc    = crc_n;
            d.hdr    = hdr_n;
            d.rx_crc = rx_n;
            d.open   = !in_eop;
            if (in_eop) begin
                if (pass) begin
                    d.fc_valid = 1'b1;
                    d.lane     = hdr_n[15:12];
                    d.init     = is_init;
                    d.blocks   = hdr_n[27:16];
                    d.limit    = hdr_n[11:0];
                end else begin
                    d.err_valid = 1'b1;
                    d.err_code  = code;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fc_valid  = q.fc_valid;
    assign fc_lane   = q.lane;
    assign fc_init   = q.init;
    assign fc_blocks = q.blocks;
    assign fc_limit  = q.limit;
    assign err_valid = q.err_valid;
    assign err_code  = q.err_code;

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
    parameter int DATA_LANES = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sop,
    input logic       in_eop,
    input logic       fc_valid,
    input logic [3:0] fc_lane,
    input logic       err_valid,
    input logic [1:0] err_code
);

    localparam logic [4:0] LANES_W = 5'(DATA_LANES);

    logic       open_q;
    logic [2:0] len_q;
    logic [2:0] last_len_q;
    logic       eop_seen_q;
    logic       acc;
    logic [2:0] len_now;

    always_comb begin
        acc     = in_valid && (in_sop || open_q);
        len_now = in_sop ? 3'd1 : ((len_q == 3'd7) ? 3'd7 : len_q + 3'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            len_q      <= 3'd0;
            last_len_q <= 3'd0;
            eop_seen_q <= 1'b0;
        end else begin
            eop_seen_q <= acc && in_eop;
            if (acc) begin
                len_q  <= len_now;
                open_q <= !in_eop;
                if (in_eop) begin
                    last_len_q <= len_now;
                end
            end
        end
    end

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fc_valid, err_valid}));

    p_result_after_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_valid || err_valid) |-> eop_seen_q);

    p_eop_gives_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eop_seen_q |-> (fc_valid || err_valid));

    p_clean_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fc_valid |-> (last_len_q == 3'd6));

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fc_valid |=> !fc_valid);

    p_len_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && (last_len_q != 3'd6)) |-> (err_code == 2'd0));

    p_lane_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fc_valid |-> (({1'b0, fc_lane} < LANES_W) || (fc_lane == 4'hF)));

endmodule

bind fc_pkt_checker fcc_checker #(
    .DATA_LANES (DATA_LANES)
) u_fcc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .fc_valid  (fc_valid),
    .fc_lane   (fc_lane),
    .err_valid (err_valid),
    .err_code  (err_code)
);

// File: tb/fc_pkt_checker_test.sv
`timescale 1ns/1ps
module fc_pkt_checker_test;

    localparam int DATA_LANES = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        fc_valid;
    logic [3:0]  fc_lane;
    logic        fc_init;
    logic [11:0] fc_blocks;
    logic [11:0] fc_limit;
    logic        err_valid;
    logic [1:0]  err_code;

    always #2 clk = ~clk;

    fc_pkt_checker #(.DATA_LANES(DATA_LANES)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .fc_valid(fc_valid),
        .fc_lane(fc_lane), .fc_init(fc_init), .fc_blocks(fc_blocks),
        .fc_limit(fc_limit), .err_valid(err_valid), .err_code(err_code)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    bit    m_open = 1'b0;
    bit    m_restart = 1'b0;
    int    m_bytes[$];
    bit    e_fc = 1'b0;
    bit    e_err = 1'b0;
    int    e_code = 0;
    int    e_lane = 0;
    int    e_init = 0;
    int    e_blocks = 0;
    int    e_limit = 0;
    string e_tag = "R1";

    function automatic int ref_crc(input int b0, input int b1, input int b2, input int b3);
        int c;
        int bytes[4];
        c = 16'hFFFF;
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
        for (int k = 0; k < 4; k++) begin
            for (int i = 7; i >= 0; i--) begin
                int fb;
                fb = ((c >> 15) & 1) ^ ((bytes[k] >> i) & 1);
                c = (c << 1) & 16'hFFFF;
                if (fb != 0) c = c ^ 16'h100B;
            end
        end
        return c;
    endfunction

    task automatic compare();
        bit bad;
        checks++;
        bad = (fc_valid !== e_fc) || (err_valid !== e_err);
        if (!bad && e_fc)
            bad = (fc_lane !== 4'(e_lane)) || (fc_init !== 1'(e_init)) ||
                  (fc_blocks !== 12'(e_blocks)) || (fc_limit !== 12'(e_limit));
        if (!bad && e_err)
            bad = (err_code !== 2'(e_code));
        if (bad) begin
            failures++;
            $display("FAIL %s: actual fc=%0b err=%0b code=%0d lane=%0d init=%0b blk=%0d lim=%0d expected fc=%0b err=%0b code=%0d lane=%0d init=%0d blk=%0d lim=%0d",
                     e_tag, fc_valid, err_valid, err_code, fc_lane, fc_init, fc_blocks, fc_limit,
                     e_fc, e_err, e_code, e_lane, e_init, e_blocks, e_limit);
        end
    endtask

    task automatic evaluate();
        int n, faults, crc_rx, op, lane;
        bit f_len, f_crc, f_op, f_lane;
        n = m_bytes.size();
        f_len = (n != 6);
        f_crc = 0; f_op = 0; f_lane = 0;
        if (n >= 4) begin
            op   = m_bytes[0] >> 4;
            lane = m_bytes[2] >> 4;
            f_op   = (op > 1);
            f_lane = !((lane < DATA_LANES) || (lane == 15));
        end
        if (n == 6) begin
            crc_rx = (m_bytes[4] << 8) | m_bytes[5];
            f_crc  = (crc_rx != ref_crc(m_bytes[0], m_bytes[1], m_bytes[2], m_bytes[3]));
        end
        faults = int'(f_len) + int'(f_crc) + int'(f_op) + int'(f_lane);
        e_fc = 0; e_err = 0;
        if (f_len)       begin e_err = 1; e_code = 0; e_tag = "R2"; end
        else if (f_crc)  begin e_err = 1; e_code = 1; e_tag = "R3"; end
        else if (f_op)   begin e_err = 1; e_code = 2; e_tag = "R4"; end
        else if (f_lane) begin e_err = 1; e_code = 3; e_tag = "R5"; end
        else begin
            e_fc     = 1;
            e_lane   = lane;
            e_init   = (op == 1) ? 1 : 0;
            e_blocks = ((m_bytes[0] & 15) << 8) | m_bytes[1];
            e_limit  = ((m_bytes[2] & 15) << 8) | m_bytes[3];
            e_tag    = m_restart ? "R10" : "R7";
        end
        if (e_err && faults > 1) e_tag = "R6";
        if (e_err && m_restart)  e_tag = "R10";
    endtask

    // one clock: check what the previous beat produced, then drive the next beat
    task automatic cycle(input bit v, input bit s, input bit e, input int d);
        @(negedge clk);
        compare();
        e_fc = 0; e_err = 0; e_tag = "R8";
        if (v && (s || m_open)) begin
            if (s) begin
                m_restart = m_open && (m_bytes.size() > 0);
                m_bytes.delete();
            end
            m_bytes.push_back(d & 255);
            if (e) begin
                evaluate();
                m_open = 0;
            end else begin
                m_open = 1;
            end
        end else if (v) begin
            e_tag = "R9";
        end
        in_valid = v; in_sop = s; in_eop = e; in_data = 8'(d);
    endtask

    task automatic send(input int b[$], input int gap_pct);
        for (int i = 0; i < b.size(); i++) begin
            while (gap_pct > 0 && ($urandom % 100) < gap_pct)
                cycle(0, 0, 0, 8'h5A);
            cycle(1, i == 0, i == b.size() - 1, b[i]);
        end
        cycle(0, 0, 0, 0);
    endtask

    function automatic void mk(ref int b[$], input int op, input int blk, input int lane,
                               input int lim, input bit crc_bad);
        int c;
        b.delete();
        b.push_back(((op & 15) << 4) | ((blk >> 8) & 15));
        b.push_back(blk & 255);
        b.push_back(((lane & 15) << 4) | ((lim >> 8) & 15));
        b.push_back(lim & 255);
        c = ref_crc(b[0], b[1], b[2], b[3]);
        if (crc_bad) c = c ^ 16'h0400;
        b.push_back((c >> 8) & 255);
        b.push_back(c & 255);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R8: watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        int p[$];
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        checks++;
        if (fc_valid !== 1'b0 || err_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1: actual fc=%0b err=%0b expected 0 0", fc_valid, err_valid);
        end
        rst_n = 1'b1;
        e_tag = "R1";
        cycle(0, 0, 0, 0);
        cycle(0, 0, 0, 0);

        // R7: clean normal packet on lane 0
        mk(p, 0, 12'hABC, 0, 12'h123, 0); send(p, 0);
        // R7: initialisation packet on management lane
        mk(p, 1, 12'h001, 15, 12'hFFF, 0); send(p, 0);
        // R8: gaps inside a packet
        mk(p, 0, 12'h7E5, 0, 12'h0A0, 0); send(p, 50);
        // R2: short, long, single byte
        mk(p, 0, 5, 0, 6, 0); p.pop_back(); send(p, 0);
        mk(p, 0, 5, 0, 6, 0); p.push_back(8'h11); send(p, 0);
        p.delete(); p.push_back(8'h00); send(p, 0);
        mk(p, 0, 5, 0, 6, 0); p.push_back(1); p.push_back(2); p.push_back(3); p.push_back(4); send(p, 0);
        // R3: CRC mismatch
        mk(p, 0, 12'h333, 0, 12'h444, 1); send(p, 0);
        // R4: bad opcode
        mk(p, 3, 12'h010, 0, 12'h020, 0); send(p, 0);
        // R5: unsupported lane
        mk(p, 0, 12'h010, 2, 12'h020, 0); send(p, 0);
        // R6: combined faults
        mk(p, 3, 1, 7, 2, 1); p.pop_back(); send(p, 0);
        mk(p, 3, 1, 7, 2, 1); send(p, 0);
        mk(p, 9, 1, 7, 2, 0); send(p, 0);
        // R9: stray bytes outside packets
        cycle(1, 0, 0, 8'hFF); cycle(1, 0, 1, 8'h10); cycle(1, 0, 0, 8'h00);
        cycle(0, 0, 0, 0);
        mk(p, 0, 12'h0F0, 0, 12'h00F, 0); send(p, 0);
        // R10: restart mid packet
        mk(p, 2, 12'h999, 3, 12'h888, 0);
        cycle(1, 1, 0, p[0]); cycle(1, 0, 0, p[1]); cycle(1, 0, 0, p[2]);
        mk(p, 1, 12'h456, 0, 12'h789, 0); send(p, 0);
        // back-to-back clean packets
        for (int k = 0; k < 3; k++) begin
            mk(p, k & 1, k * 100, (k == 1) ? 15 : 0, k * 7, 0);
            for (int i = 0; i < 6; i++) cycle(1, i == 0, i == 5, p[i]);
        end
        cycle(0, 0, 0, 0);

        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom % 16;
            mk(p, (r < 10) ? ($urandom % 2) : ($urandom % 16), $urandom % 4096,
               (r < 12) ? ((($urandom % 2) != 0) ? 15 : 0) : ($urandom % 16),
               $urandom % 4096, (r == 3));
            if (r == 5) p.pop_back();
            if (r == 6) p.push_back($urandom % 256);
            send(p, 20);
        end
        cycle(0, 0, 0, 0);
        finish_run();
    end

endmodule